// File: doc/BRIEF.md
# Filtered Input-Capture Timer

This block is a free-running timer counter with a single capture channel. An asynchronous input pin is brought into the clock domain by a two-stage synchronizer. It then passes a glitch filter that changes its output level only after the synchronized input has held a new level for a programmed number of clocks. An edge detector follows the filter. When that detector sees the selected transition, the current counter value is stored in a capture register and a sticky flag is set. The flag can also drive an interrupt request.

Software configures the block through a simple write port with three registers: a counter start value, a modulo value and a control word. The counter counts from the start value up to the modulo value and then returns to the start value. A power-of-two prescaler sets its rate, and a run bit stops and restarts it. The filter length and the edge choice are treated as static settings. They are accepted only while the counter is stopped, so a running measurement cannot have its filter changed under it.

Top module: `icap_timer`

## Requirements
- R1: After reset, the counter value, the capture value, the flag and the interrupt output are all zero, and the counter is stopped.
- R2: A write to address 0 sets the start value and also loads it into the counter. A write to address 1 sets the modulo value. While running with prescaler 0, the counter advances by one every clock, and the clock after it equals the modulo value it takes the start value.
- R3: Control bits [3:1] hold a prescaler code p. While running, the counter advances once every 2^p clocks.
- R4: Control bit 0 is the run bit. While it is 0, the counter holds its value.
- R5: Control bits [9:6] hold a filter value F, which sets a threshold N = 4*F, or N = 1 when F = 0. A synchronized input level that lasts N clocks changes the filtered level. A level that lasts N-1 clocks is rejected completely and causes no capture.
- R6: If a pin change is first sampled at clock edge E0, the flag and the capture value update at edge E0+N+2. They do not update earlier.
- R7: Control bits [5:4] select the edge. Bit 4 enables capture on filtered rising transitions and bit 5 enables capture on filtered falling transitions. The code 00 captures nothing.
- R8: On a capture, the capture register takes the counter value held in the cycle before the capture edge, and the flag is set. The flag stays set until a flag_clr strobe clears it. If a capture and a clear occur in the same cycle, the flag stays set.
- R9: The irq output is high exactly when the flag is set and control bit 10 (interrupt enable) is set.
- R10: A control write made while the counter is running updates the run, prescaler and interrupt-enable fields. The filter and edge fields of that write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 start, 1 modulo, 2 control |
| cfg_wdata | input | 16 | Configuration write data |
| pin | input | 1 | Asynchronous capture input |
| flag_clr | input | 1 | Clears the capture flag |
| cnt | output | 16 | Current counter value |
| cap | output | 16 | Last captured counter value |
| flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the filter boundary: a pulse exactly one clock shorter than the threshold has to be told apart from one that is exactly at the threshold. This has to hold for several filter values, including the largest value and the bypass case. The stimulus drives the pin on the falling clock edge and holds it for a counted number of clocks, so the synchronized width equals the driven width. A second hard case is a clear strobe that arrives in the same cycle as a capture. To reach it, the bench times the strobe against the fixed input-to-flag latency.

// File: rtl/icap_timer.sv
module icap_timer #(
  parameter int CNT_W  = 16,
  parameter int DW     = 16,
  parameter int FLT_W  = 4,
  parameter int PS_W   = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             pin,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             flag,
  output logic             irq
);
  localparam int PSC_W  = (1 << PS_W) - 1;
  localparam int FCNT_W = FLT_W + 2;
  localparam int B_PS   = 1;
  localparam int B_EDG  = B_PS + PS_W;
  localparam int B_FLT  = B_EDG + 2;
  localparam int B_IEN  = B_FLT + FLT_W;

  logic [CNT_W-1:0]  start_q, mod_q, cnt_q, cap_q;
  logic              run_q, ien_q, flag_q;
  logic [PS_W-1:0]   ps_q;
  logic [1:0]        edge_q;
  logic [FLT_W-1:0]  filt_q;
  logic [PSC_W-1:0]  pre_q, pre_lim;
  logic [SYNC_N-1:0] sync_q;
  logic [FCNT_W-1:0] fcnt_q, thr;
  logic              lvl_q, lvl_prev_q;
  logic              tick, ctl_wr, s_in, rise, fall, hit;

  assign ctl_wr  = cfg_we && (cfg_addr == 2'd2);
  assign pre_lim = (PSC_W'(1) << ps_q) - PSC_W'(1);
  assign tick    = run_q && (pre_q >= pre_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      mod_q   <= '0;
      run_q   <= 1'b0;
      ps_q    <= '0;
      edge_q  <= '0;
      filt_q  <= '0;
      ien_q   <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == 2'd0) start_q <= cfg_wdata[CNT_W-1:0];
      if (cfg_we && cfg_addr == 2'd1) mod_q   <= cfg_wdata[CNT_W-1:0];
      if (ctl_wr) begin
        run_q <= cfg_wdata[0];
        ps_q  <= cfg_wdata[B_EDG-1:B_PS];
        ien_q <= cfg_wdata[B_IEN];
        if (!run_q) begin
          edge_q <= cfg_wdata[B_FLT-1:B_EDG];
          filt_q <= cfg_wdata[B_IEN-1:B_FLT];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (!run_q || tick) pre_q <= '0;
    else                 pre_q <= pre_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (cfg_we && cfg_addr == 2'd0) cnt_q <= cfg_wdata[CNT_W-1:0];
    else if (tick)                       cnt_q <= (cnt_q == mod_q) ? start_q : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], pin};
  end
  assign s_in = sync_q[SYNC_N-1];

  assign thr = (filt_q == '0) ? FCNT_W'(1) : {filt_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q     <= '0;
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_prev_q <= lvl_q;
      if (s_in != lvl_q) begin
        if (fcnt_q >= thr - FCNT_W'(1)) begin
          lvl_q  <= s_in;
          fcnt_q <= '0;
        end else begin
          fcnt_q <= fcnt_q + FCNT_W'(1);
        end
      end else begin
        fcnt_q <= '0;
      end
    end
  end

  assign rise = lvl_q & ~lvl_prev_q;
  assign fall = ~lvl_q & lvl_prev_q;
  assign hit  = (rise & edge_q[0]) | (fall & edge_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else if (hit) begin
      cap_q  <= cnt_q;
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign cap  = cap_q;
  assign flag = flag_q;
  assign irq  = flag_q & ien_q;
endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             flag_clr,
  input logic             flag,
  input logic             hit,
  input logic [CNT_W-1:0] cap,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic [PS_W-1:0]  ps,
  input logic [CNT_W-1:0] start,
  input logic [CNT_W-1:0] modulo
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !hit |=> !flag); // R8
  AST_CAP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap) |-> flag); // R8
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cfg_we |=> $stable(cnt)); // R4
  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cfg_we && ps == '0 && cnt == modulo |=> cnt == start); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cfg_we && ps == '0 && cnt != modulo |=> cnt == CNT_W'($past(cnt) + CNT_W'(1))); // R2
endmodule

bind icap_timer icap_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .flag_clr(flag_clr),
  .flag(flag), .hit(hit), .cap(cap), .cnt(cnt), .run(run_q),
  .ps(ps_q), .start(start_q), .modulo(mod_q)
);

// File: tb/sim_icap_timer.sv
module sim_icap_timer;
  localparam int CLK_PER = 10;
  localparam int NV = 11;
  // filter, edge code, pulse width, expected captures
  localparam int VEC [NV][4] = '{
    '{1, 1, 3, 0}, '{1, 1, 4, 1}, '{3, 1, 11, 0}, '{3, 1, 12, 1},
    '{2, 2, 7, 0}, '{2, 2, 8, 1}, '{2, 3, 8, 2},  '{0, 1, 1, 1},
    '{15, 1, 59, 0}, '{15, 1, 60, 1}, '{1, 0, 10, 0}
  };

  logic clk = 0, rst_n = 0, cfg_we = 0, pin = 0, man_clr = 0, mon_clr = 0, mon_en = 0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cnt, cap;
  logic flag, irq, flag_clr;
  int nchk = 0, nfail = 0, ncap = 0;
  bit finished = 0;

  assign flag_clr = man_clr | mon_clr;
  always #(CLK_PER/2) clk = ~clk;

  icap_timer u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin(pin), .flag_clr(flag_clr), .cnt(cnt), .cap(cap),
    .flag(flag), .irq(irq));

  always @(negedge clk) begin
    mon_clr <= 1'b0;
    if (mon_en && flag) begin
      ncap++;
      mon_clr <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input bit run, input int ps, input int edg, input int filt, input bit ien);
    return {5'b0, ien, 4'(filt), 2'(edg), 3'(ps), run};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(input int filt, input int edg, input int ps, input bit ien);
    wr(2, ctl(0, ps, edg, filt, ien));
    wr(2, ctl(0, ps, edg, filt, ien));
    wr(2, ctl(1, ps, edg, filt, ien));
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    pin = 1;
    repeat (w) @(negedge clk);
    pin = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int prev, c0, chg, n, exp;
    repeat (3) @(negedge clk);
    chk(cnt == 0 && cap == 0 && flag == 0 && irq == 0, "R1 reset outputs", {cnt, cap, 15'b0, flag}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cnt == 0, "R1 stopped after reset", cnt, 0);

    // table walk: filter boundaries and edge modes
    wr(0, 0); wr(1, 16'hFFFF);
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][0], VEC[i][1], 0, 0);
      ncap = 0; mon_en = 1;
      pulse(VEC[i][2]);
      repeat (100) @(negedge clk);
      mon_en = 0;
      @(negedge clk);
      chk(ncap == VEC[i][3], $sformatf("R5 R7 vector %0d", i), ncap, VEC[i][3]);
    end

    // R2 load, step and wrap
    wr(2, ctl(0, 0, 1, 1, 0));
    wr(1, 8); wr(0, 5);
    chk(cnt == 5, "R2 start load", cnt, 5);
    wr(2, ctl(1, 0, 1, 1, 0));
    for (int i = 0; i < 12; i++) begin
      prev = cnt;
      @(negedge clk);
      exp = (prev == 8) ? 5 : prev + 1;
      chk(cnt == exp, "R2 step/wrap", cnt, exp);
    end

    // R3 prescaler divide by 4
    wr(2, ctl(0, 2, 1, 1, 0));
    wr(1, 16'hFFFF); wr(0, 0);
    wr(2, ctl(1, 2, 1, 1, 0));
    chg = 0; prev = cnt;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (cnt != prev) chg++;
      prev = cnt;
    end
    chk(chg == 4, "R3 prescale advances", chg, 4);

    // R4 stop holds
    wr(2, ctl(0, 0, 1, 1, 0));
    c0 = cnt;
    repeat (10) @(negedge clk);
    chk(cnt == c0, "R4 stopped counter", cnt, c0);

    // R6 latency and R8 captured value, F=1 -> N=4
    setup(1, 1, 0, 0);
    n = 4;
    pin = 1;
    repeat (n + 2) @(negedge clk);
    chk(flag == 0, "R6 no early capture", flag, 0);
    c0 = cnt;
    @(negedge clk);
    chk(flag == 1, "R6 capture edge", flag, 1);
    chk(cap == c0, "R8 captured value", cap, c0);

    // R9 irq gating
    chk(irq == 0, "R9 irq masked", irq, 0);
    wr(2, ctl(1, 0, 1, 1, 1));
    chk(irq == 1, "R9 irq enabled", irq, 1);

    // R8 sticky then clear
    repeat (20) @(negedge clk);
    chk(flag == 1, "R8 sticky flag", flag, 1);
    man_clr = 1; @(negedge clk); man_clr = 0;
    chk(flag == 0 && irq == 0, "R8 clear", flag, 0);

    // R7 falling transition ignored in rising mode
    pin = 0;
    repeat (30) @(negedge clk);
    chk(flag == 0, "R7 no capture on fall", flag, 0);

    // R8 capture beats clear in the same cycle
    c0 = cap;
    pin = 1;
    repeat (n + 2) @(negedge clk);
    man_clr = 1;
    @(negedge clk);
    man_clr = 0;
    chk(flag == 1, "R8 capture wins over clear", flag, 1);
    chk(cap != c0, "R8 capture updated", cap, c0 + 1);
    pin = 0;
    repeat (30) @(negedge clk);
    man_clr = 1; @(negedge clk); man_clr = 0;

    // R10 filter and edge fields ignored while running
    wr(2, ctl(1, 0, 0, 15, 0));
    pulse(4);
    repeat (20) @(negedge clk);
    chk(flag == 1, "R10 old filter and edge kept", flag, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule